// File: doc/BRIEF.md
# Dual Timer/Counter with Selectable Count Chains

This block holds two timer/counter channels for a small microcontroller. Each channel keeps a low byte and a high byte, and it has a run bit, an overflow flag and a source select. The count source is either an internal tick, which is one strobe per machine cycle, or a falling edge on an external pin. The pin is sampled once per machine cycle, so an edge is seen only when one sample is high and the next sample is low. A 2-bit mode field sets how the two bytes are chained. The options are a 5-bit prescaler that feeds the high byte, a 16-bit cascade, an 8-bit counter that reloads from the high byte, or two independent 8-bit counters.

The split arrangement applies only to channel 0. Its low byte stays under channel 0's own controls. Its high byte counts machine cycles, is gated by channel 1's run bit, and sets channel 1's flag. When channel 1 itself is put in the split mode it freezes. Software writes the byte registers, the configuration byte and the control nibble at any time, and it clears a flag either with a control write or with an acknowledge pulse.

Each channel has a pin sampler, which is a two-state machine. `SMP_LOW` means the last sample was low. `SMP_HIGH` means the last sample was high. On a machine-cycle strobe, `SMP_LOW` moves to `SMP_HIGH` when the pin is high. On a strobe, `SMP_HIGH` moves back to `SMP_LOW` when the pin is low, and that move is the count event. The chain mode is an enumerated selector with four values: `MODE_PRE13`, `MODE_CAS16`, `MODE_RLD8` and `MODE_SPLIT`.

Top module: `tmr_pair`

## Requirements
- R1: After reset, both count values, both flags, both run bits and the whole configuration are zero. Zero configuration means mode 00 with the internal source.
- R2: With the internal source selected and the run bit set, a channel advances by exactly one on each cycle in which `mc_tick` is high. With the run bit clear, or with no strobe, the count holds.
- R3: With the external source selected (configuration source bit = 1), a channel advances by one on a strobe where the pin is low and the previous strobe's sample was high. Pin activity between strobes is not seen, and a pin held low does not count again.
- R4: Mode 00 counts in the low 5 bits of the low byte. When those bits wrap from 31 to 0, the high byte increments. Low-byte bits 7:5 never change by counting. The flag is set when the high byte wraps from 0xFF.
- R5: Mode 01 counts {high, low} as one 16-bit value. The flag is set on the wrap from 0xFFFF to 0x0000.
- R6: Mode 10 counts the low byte only. On a low-byte wrap from 0xFF, the low byte is loaded from the high byte, the flag is set, and the high byte is unchanged.
- R7: In mode 11, channel 0's low byte is an 8-bit counter under channel 0's source and run bit, and it sets flag 0. Channel 0's high byte counts strobes while run bit 1 is set, and it sets flag 1 on its wrap from 0xFF.
- R8: Channel 1 in mode 11 holds its count whatever its run bit and strobes are.
- R9: While channel 0 is in mode 11 and channel 1 is not, channel 1 counts regardless of run bit 1, and its overflow does not set flag 1.
- R10: A flag stays set until `irq_ack` clears it or a control write loads it. An overflow in the same cycle as a clear leaves the flag set.
- R11: A byte write takes effect at the next edge. A write to either byte of a channel cancels that channel's count event in the same cycle.
- R12: Configuration byte layout: bits 1:0 are the channel 0 mode, bit 2 is the channel 0 source, bits 5:4 are the channel 1 mode, bit 6 is the channel 1 source, and bits 3 and 7 are ignored. Control nibble layout: bit 0 is run 0, bit 1 is run 1, bit 2 is flag 0, bit 3 is flag 1. The count outputs are {high, low}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 2 | External count pins, one per channel |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_wdata | input | 8 | Configuration byte |
| ctl_we | input | 1 | Control nibble write enable |
| ctl_wdata | input | 4 | Run bits and flag values |
| lo_we | input | 2 | Low byte write enable per channel |
| hi_we | input | 2 | High byte write enable per channel |
| wr_data | input | BYTE_W | Byte write data |
| irq_ack | input | 2 | Flag clear pulse per channel |
| cnt0 | output | 2*BYTE_W | Channel 0 {high, low} |
| cnt1 | output | 2*BYTE_W | Channel 1 {high, low} |
| ovf | output | 2 | Overflow flags |

## Verification
The hardest situation to reach is the coupling between the channels in the split mode. Channel 0's high byte runs from channel 1's run bit and owns flag 1, while channel 1 keeps counting with its overflow discarded. To get there, the stimulus preloads both high bytes just below 0xFF and steps single strobes, so that all three wraps fall on known cycles. Pin edges landing exactly on strobes, and flag clears that coincide with overflows, are built the same way by hand. A long random phase then mixes writes, acknowledges and mode changes while a behavioural model is compared on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_PRE13 = 2'b00,
        MODE_CAS16 = 2'b01,
        MODE_RLD8  = 2'b10,
        MODE_SPLIT = 2'b11
    } tmr_mode_e;

    typedef enum logic {
        SMP_LOW  = 1'b0,
        SMP_HIGH = 1'b1
    } smp_state_e;

    typedef struct packed {
        logic      src_ext;
        tmr_mode_e mode;
    } chan_cfg_t;

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);

    smp_state_e state_q;
    smp_state_e state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SMP_LOW;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SMP_LOW:  if (tick && pin)  state_n = SMP_HIGH;
            SMP_HIGH: if (tick && !pin) state_n = SMP_LOW;
        endcase
    end

    always_comb begin
        fall = 1'b0;
        unique case (state_q)
            SMP_LOW:  fall = 1'b0;
            SMP_HIGH: fall = tick && !pin;
        endcase
    end

    // R3
    fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (state_q == SMP_LOW));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode,
    input  logic              inc_lo,
    input  logic              inc_hi,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              ovf_lo,
    output logic              ovf_hi
);

    localparam logic [BYTE_W-1:0] BYTE_MAX = {BYTE_W{1'b1}};
    localparam logic [PRE_W-1:0]  PRE_MAX  = {PRE_W{1'b1}};

    logic [BYTE_W-1:0] lo_n;
    logic [BYTE_W-1:0] hi_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    always_comb begin
        lo_n   = lo_q;
        hi_n   = hi_q;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        if (lo_we || hi_we) begin
            if (lo_we) lo_n = wdata;
            if (hi_we) hi_n = wdata;
        end else begin
            unique case (mode)
                MODE_PRE13: begin
                    if (inc_lo) begin
                        if (lo_q[PRE_W-1:0] == PRE_MAX) begin
                            lo_n[PRE_W-1:0] = '0;
                            hi_n            = hi_q + 1'b1;
                            ovf_lo          = (hi_q == BYTE_MAX);
                        end else begin
                            lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
                        end
                    end
                end
                MODE_CAS16: begin
                    if (inc_lo) begin
                        {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
                        ovf_lo       = (hi_q == BYTE_MAX) && (lo_q == BYTE_MAX);
                    end
                end
                MODE_RLD8: begin
                    if (inc_lo) begin
                        if (lo_q == BYTE_MAX) begin
                            lo_n   = hi_q;
                            ovf_lo = 1'b1;
                        end else begin
                            lo_n = lo_q + 1'b1;
                        end
                    end
                end
                MODE_SPLIT: begin
                    if (inc_lo) begin
                        lo_n   = lo_q + 1'b1;
                        ovf_lo = (lo_q == BYTE_MAX);
                    end
                    if (inc_hi) begin
                        hi_n   = hi_q + 1'b1;
                        ovf_hi = (hi_q == BYTE_MAX);
                    end
                end
            endcase
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_lo && !inc_hi && !lo_we && !hi_we) |=> $stable({hi_q, lo_q}));

    // R4
    pre_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PRE13 && !lo_we) |=>
            (lo_q[BYTE_W-1:PRE_W] == $past(lo_q[BYTE_W-1:PRE_W])));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RLD8 && inc_lo && lo_q == BYTE_MAX && !lo_we && !hi_we) |=>
            (lo_q == $past(hi_q)));

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mc_tick,
    input  logic [1:0]          cnt_pin,
    input  logic                cfg_we,
    input  logic [7:0]          cfg_wdata,
    input  logic                ctl_we,
    input  logic [3:0]          ctl_wdata,
    input  logic [1:0]          lo_we,
    input  logic [1:0]          hi_we,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [1:0]          irq_ack,
    output logic [2*BYTE_W-1:0] cnt0,
    output logic [2*BYTE_W-1:0] cnt1,
    output logic [1:0]          ovf
);

    localparam int CH    = 2;
    localparam int CFG_W = 4;

    chan_cfg_t         cfg_q [CH];
    logic [CH-1:0]     run_q;
    logic [CH-1:0]     flag_q;
    logic [CH-1:0]     flag_n;
    logic [CH-1:0]     ext_fall;
    logic [CH-1:0]     ev;
    logic [CH-1:0]     inc_lo;
    logic [CH-1:0]     inc_hi;
    logic [CH-1:0]     ovf_lo;
    logic [CH-1:0]     ovf_hi;
    logic [CH-1:0]     set_f;
    logic [BYTE_W-1:0] lo_q [CH];
    logic [BYTE_W-1:0] hi_q [CH];
    logic              split0;
    logic              rsvd_unused;

    assign rsvd_unused = cfg_wdata[3] ^ cfg_wdata[7];

    for (genvar c = 0; c < CH; c++) begin : g_ch
        tmr_edge_det u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (mc_tick),
            .pin  (cnt_pin[c]),
            .fall (ext_fall[c])
        );

        assign ev[c] = cfg_q[c].src_ext ? ext_fall[c] : mc_tick;

        tmr_chan #(
            .BYTE_W(BYTE_W),
            .PRE_W (PRE_W)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (cfg_q[c].mode),
            .inc_lo(inc_lo[c]),
            .inc_hi(inc_hi[c]),
            .lo_we (lo_we[c]),
            .hi_we (hi_we[c]),
            .wdata (wr_data),
            .lo_q  (lo_q[c]),
            .hi_q  (hi_q[c]),
            .ovf_lo(ovf_lo[c]),
            .ovf_hi(ovf_hi[c])
        );
    end

    assign split0 = (cfg_q[0].mode == MODE_SPLIT);

    always_comb begin
        inc_lo[0] = run_q[0] && ev[0];
        inc_hi[0] = split0 && run_q[1] && mc_tick;
        inc_lo[1] = (cfg_q[1].mode != MODE_SPLIT) && ev[1] && (split0 || run_q[1]);
        inc_hi[1] = 1'b0;
        set_f[0]  = ovf_lo[0];
        set_f[1]  = split0 ? ovf_hi[0] : (ovf_lo[1] || ovf_hi[1]);
        for (int c = 0; c < CH; c++) begin
            flag_n[c] = set_f[c] ||
                        (ctl_we ? ctl_wdata[2+c] : (flag_q[c] && !irq_ack[c]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < CH; c++) cfg_q[c] <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (cfg_we) begin
                for (int c = 0; c < CH; c++) begin
                    cfg_q[c] <= chan_cfg_t'(cfg_wdata[CFG_W*c +: 3]);
                end
            end
            if (ctl_we) run_q <= ctl_wdata[1:0];
            flag_q <= flag_n;
        end
    end

    always_comb begin
        cnt0 = {hi_q[0], lo_q[0]};
        cnt1 = {hi_q[1], lo_q[1]};
        ovf  = flag_q;
    end

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[0] && !irq_ack[0] && !ctl_we) |=> ovf[0]);

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_lo[0] |=> ovf[0]);

    // R8
    ch1_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[1].mode == MODE_SPLIT && !lo_we[1] && !hi_we[1]) |=> $stable(cnt1));

    // R3
    ext_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[0].src_ext && cfg_q[0].mode == MODE_CAS16 && run_q[0] &&
         ext_fall[0] && !lo_we[0] && !hi_we[0]) |=> (cnt0 == $past(cnt0) + 1'b1));

endmodule

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_tick = 1'b0;
    logic [1:0]  cnt_pin = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        ctl_we = 1'b0;
    logic [3:0]  ctl_wdata = '0;
    logic [1:0]  lo_we = '0;
    logic [1:0]  hi_we = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  irq_ack = '0;
    logic [15:0] cnt0;
    logic [15:0] cnt1;
    logic [1:0]  ovf;

    int    n_chk = 0;
    int    n_err = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";

    int m_lo [2];
    int m_hi [2];
    int m_mode [2];
    bit m_f [2];
    bit m_run [2];
    bit m_src [2];
    bit m_samp [2];
    bit s_a;
    bit s_b;

    always #5 clk = ~clk;

    tmr_pair u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mc_tick  (mc_tick),
        .cnt_pin  (cnt_pin),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .ctl_we   (ctl_we),
        .ctl_wdata(ctl_wdata),
        .lo_we    (lo_we),
        .hi_we    (hi_we),
        .wr_data  (wr_data),
        .irq_ack  (irq_ack),
        .cnt0     (cnt0),
        .cnt1     (cnt1),
        .ovf      (ovf)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One step of a non-split chain, or of a low byte in the split mode.
    task automatic m_count(input int md, inout int lo, inout int hi, output bit ov);
        ov = 0;
        case (md)
            0: begin
                if ((lo & 31) == 31) begin
                    lo = lo & 224;
                    if (hi == 255) begin hi = 0; ov = 1; end
                    else hi = hi + 1;
                end else lo = lo + 1;
            end
            1: begin
                if (lo == 255) begin
                    lo = 0;
                    if (hi == 255) begin hi = 0; ov = 1; end
                    else hi = hi + 1;
                end else lo = lo + 1;
            end
            2: begin
                if (lo == 255) begin lo = hi; ov = 1; end
                else lo = lo + 1;
            end
            default: begin
                if (lo == 255) begin lo = 0; ov = 1; end
                else lo = lo + 1;
            end
        endcase
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_lo[c] = 0; m_hi[c] = 0; m_mode[c] = 0;
                m_f[c] = 0; m_run[c] = 0; m_src[c] = 0; m_samp[c] = 0;
            end
        end else begin
            bit ev [2];
            bit split0;
            bit o;
            bit nf;
            s_a = 0;
            s_b = 0;
            split0 = (m_mode[0] == 3);
            for (int c = 0; c < 2; c++) begin
                bit e;
                e = mc_tick && m_samp[c] && !cnt_pin[c];
                if (mc_tick) m_samp[c] = cnt_pin[c];
                ev[c] = m_src[c] ? e : mc_tick;
            end
            if (lo_we[0] || hi_we[0]) begin
                if (lo_we[0]) m_lo[0] = int'(wr_data);
                if (hi_we[0]) m_hi[0] = int'(wr_data);
            end else begin
                if (m_run[0] && ev[0]) m_count(m_mode[0], m_lo[0], m_hi[0], s_a);
                if (split0 && m_run[1] && mc_tick) begin
                    if (m_hi[0] == 255) begin m_hi[0] = 0; s_b = 1; end
                    else m_hi[0] = m_hi[0] + 1;
                end
            end
            if (lo_we[1] || hi_we[1]) begin
                if (lo_we[1]) m_lo[1] = int'(wr_data);
                if (hi_we[1]) m_hi[1] = int'(wr_data);
            end else if (m_mode[1] != 3 && ev[1] && (split0 || m_run[1])) begin
                m_count(m_mode[1], m_lo[1], m_hi[1], o);
                if (!split0) s_b = o;
            end
            for (int c = 0; c < 2; c++) begin
                nf = ctl_we ? ctl_wdata[2+c] : (m_f[c] && !irq_ack[c]);
                m_f[c] = nf || (c == 0 ? s_a : s_b);
            end
            if (ctl_we) begin
                m_run[0] = ctl_wdata[0];
                m_run[1] = ctl_wdata[1];
            end
            if (cfg_we) begin
                m_mode[0] = int'(cfg_wdata[1:0]);
                m_src[0]  = cfg_wdata[2];
                m_mode[1] = int'(cfg_wdata[5:4]);
                m_src[1]  = cfg_wdata[6];
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({cur_req, " model cnt0"}, int'(cnt0), m_hi[0] * 256 + m_lo[0]);
            check({cur_req, " model cnt1"}, int'(cnt1), m_hi[1] * 256 + m_lo[1]);
            check({cur_req, " model ovf"}, int'(ovf), int'({m_f[1], m_f[0]}));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        repeat (n) begin
            mc_tick = 1'b1;
            @(negedge clk);
            mc_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_ctl(input logic [3:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_byte(input int ch, input bit hi, input logic [7:0] v);
        wr_data = v;
        if (hi) hi_we[ch] = 1'b1; else lo_we[ch] = 1'b1;
        @(negedge clk);
        lo_we = '0; hi_we = '0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        cur_req = "R1";
        check("R1 reset cnt0", int'(cnt0), 0);
        check("R1 reset cnt1", int'(cnt1), 0);
        check("R1 reset ovf", int'(ovf), 0);

        cur_req = "R2";
        tick_n(3);
        check("R2 stopped cnt0", int'(cnt0), 0);
        set_cfg(8'h11);
        set_ctl(4'h1);
        tick_n(5);
        check("R2 run cnt0", int'(cnt0), 5);
        check("R2 run1 clear cnt1", int'(cnt1), 0);
        idle(6);
        check("R2 no strobe hold", int'(cnt0), 5);

        cur_req = "R5";
        wr_byte(0, 1, 8'hFF);
        wr_byte(0, 0, 8'hFD);
        tick_n(5);
        check("R5 wrap cnt0", int'(cnt0), 2);
        check("R5 flag0", int'(ovf[0]), 1);

        cur_req = "R10";
        idle(3);
        check("R10 sticky", int'(ovf[0]), 1);
        irq_ack[0] = 1'b1; idle(1); irq_ack[0] = 1'b0;
        check("R10 ack clears", int'(ovf[0]), 0);
        set_ctl(4'h5);
        check("R10 write sets", int'(ovf[0]), 1);
        set_ctl(4'h1);
        check("R10 write clears", int'(ovf[0]), 0);

        cur_req = "R4";
        set_cfg(8'h00);
        wr_byte(0, 0, 8'hFE);
        wr_byte(0, 1, 8'hFF);
        tick_n(1);
        check("R4 prescale step", int'(cnt0), 16'hFFFF);
        tick_n(1);
        check("R4 wrap keeps 7:5", int'(cnt0), 16'h00E0);
        check("R4 flag0", int'(ovf[0]), 1);

        cur_req = "R6";
        set_cfg(8'h02);
        set_ctl(4'h1);
        wr_byte(0, 1, 8'h80);
        wr_byte(0, 0, 8'hFD);
        tick_n(5);
        check("R6 reload cnt0", int'(cnt0), 16'h8082);
        check("R6 flag0", int'(ovf[0]), 1);

        cur_req = "R3";
        set_cfg(8'h05);
        set_ctl(4'h1);
        wr_byte(0, 0, 8'h00);
        wr_byte(0, 1, 8'h00);
        cnt_pin[0] = 1'b1; tick_n(1);
        cnt_pin[0] = 1'b0; tick_n(1);
        check("R3 one edge", int'(cnt0), 1);
        cnt_pin[0] = 1'b1; idle(2);
        cnt_pin[0] = 1'b0; idle(2);
        tick_n(1);
        tick_n(3);
        check("R3 unsampled pulse and held low", int'(cnt0), 1);
        cnt_pin[0] = 1'b1; tick_n(1);
        cnt_pin[0] = 1'b0; tick_n(1);
        check("R3 second edge", int'(cnt0), 2);

        cur_req = "R7";
        set_cfg(8'h13);
        set_ctl(4'h3);
        wr_byte(0, 0, 8'hFE);
        wr_byte(0, 1, 8'hFE);
        tick_n(3);
        check("R7 split both wrap", int'(cnt0), 16'h0101);
        check("R7 flags both", int'(ovf), 3);
        set_ctl(4'h1);
        tick_n(2);
        check("R7 high gated by run1", int'(cnt0), 16'h0103);
        check("R7 no flags", int'(ovf), 0);

        cur_req = "R9";
        set_ctl(4'h0);
        wr_byte(1, 1, 8'hFF);
        wr_byte(1, 0, 8'hFE);
        tick_n(3);
        check("R9 ch1 counts with run1 clear", int'(cnt1), 1);
        check("R9 flag1 not set", int'(ovf[1]), 0);
        check("R9 ch0 stopped", int'(cnt0), 16'h0103);

        cur_req = "R8";
        set_cfg(8'h33);
        set_ctl(4'h3);
        tick_n(4);
        check("R8 ch1 frozen", int'(cnt1), 1);
        check("R8 ch0 split counts", int'(cnt0), 16'h0507);

        cur_req = "R11";
        set_cfg(8'h11);
        set_ctl(4'h1);
        mc_tick = 1'b1; lo_we[0] = 1'b1; wr_data = 8'h40;
        idle(1);
        mc_tick = 1'b0; lo_we = '0;
        idle(1);
        check("R11 write wins", int'(cnt0), 16'h0540);
        tick_n(1);
        check("R11 count after write", int'(cnt0), 16'h0541);

        cur_req = "R10";
        wr_byte(0, 1, 8'hFF);
        wr_byte(0, 0, 8'hFF);
        mc_tick = 1'b1; irq_ack[0] = 1'b1;
        idle(1);
        mc_tick = 1'b0; irq_ack[0] = 1'b0;
        idle(1);
        check("R10 set wins over ack", int'(ovf[0]), 1);
        check("R10 wrap value", int'(cnt0), 0);

        cur_req = "R12";
        repeat (4000) begin
            @(negedge clk);
            mc_tick   = ($urandom % 3) != 0;
            cnt_pin   = 2'($urandom);
            cfg_we    = ($urandom % 40) == 0;
            cfg_wdata = 8'($urandom);
            ctl_we    = ($urandom % 20) == 0;
            ctl_wdata = 4'($urandom);
            lo_we     = (($urandom % 25) == 0) ? 2'($urandom) : 2'b00;
            hi_we     = (($urandom % 25) == 0) ? 2'($urandom) : 2'b00;
            wr_data   = (($urandom % 2) == 0) ? 8'hFE : 8'($urandom);
            irq_ack   = (($urandom % 10) == 0) ? 2'($urandom) : 2'b00;
        end
        @(negedge clk);
        mc_tick = 1'b0; cfg_we = 1'b0; ctl_we = 1'b0;
        lo_we = '0; hi_we = '0; irq_ack = '0;
        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule